// File: doc/BRIEF.md
# Serial Link Parity Error Monitor

This block sits behind the receive side of a serial video link and watches every 28-bit forward-channel frame after deserialization. Each frame holds 27 payload bits (video, sync and control-channel bits) and one parity bit. The monitor checks the parity of each valid frame, counts frames whose parity fails in a saturating 16-bit counter, and drives a registered pass status that drops on any failing frame and comes back on the next good one.

The count is read as two bytes through a simple address/read-data port that stands in for the chip's register bus. Reading the low byte captures the upper byte into a shadow register, so a low-then-high read pair returns one coherent 16-bit value even while errors keep arriving. Whenever the link-lock input is low, the counter and the shadow are cleared, incoming frames are ignored and the pass output is held low.

Top module: `slpm_parity_monitor`

## Requirements
- R1: A frame is good when the XOR of all 28 bits of `frame_i` is 0 (bit 27 equals the XOR of bits 26..0, even parity); it is checked only in cycles where `frame_vld_i` and `lock_i` are both high, and a frame with `frame_vld_i` low changes neither the count nor `pass_o`.
- R2: Each checked frame that fails parity raises the error count by exactly one, visible from the clock edge at which the frame is sampled.
- R3: The error count saturates at 0xFFFF and does not wrap to zero.
- R4: A cycle with `lock_i` low clears the error count and the shadow byte to zero at that clock edge.
- R5: `pass_o` is low after the edge that samples a failing checked frame.
- R6: `pass_o` is low after reset and while `lock_i` is low, and goes high at the edge that samples the first good checked frame after that or after an error.
- R7: While `lock_i` is low, frames with bad or good parity neither raise the count nor raise `pass_o`.
- R8: A read (`rd_en_i` high) at address 0x1A returns count bits 7..0 on `rd_data_o` after the next edge and captures count bits 15..8 into the shadow; a read at 0x1B returns the shadow as it stood before that edge.
- R9: A read at any address other than 0x1A and 0x1B returns 0x00.
- R10: Synchronous active-high reset clears the count, the shadow and `rd_data_o` and sets `pass_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_i | input | 1 | Link locked indication |
| frame_vld_i | input | 1 | Frame word valid this cycle |
| frame_i | input | 28 | Received frame, parity in bit 27 |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| pass_o | output | 1 | Parity pass status, high when good |
| rd_data_o | output | 8 | Registered read data |

## Verification
The properties assume `lock_i`, `frame_vld_i` and the read strobe are synchronous to `clk` and settle before each rising edge, and that reset is held for at least one edge before the first checked cycle. The bench changes every input on the falling edge only and samples outputs on the following falling edge, so each frame and read is seen by exactly one rising edge. Reads are issued only while lock is high, which keeps the shadow capture separate from the lock-loss clear that would otherwise win in the same cycle.

// File: rtl/slpm_pkg.sv
package slpm_pkg;
  localparam int FRAME_W_DEF = 28;
  localparam int CNT_W_DEF   = 16;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W_DEF  = 8;
  localparam logic [7:0] BASE_ADDR_DEF = 8'h1A;

  typedef struct packed {
    logic chk_en;
    logic par_err;
  } chk_res_t;
endpackage

// File: rtl/slpm_parity_chk.sv
module slpm_parity_chk
  import slpm_pkg::*;
#(
  parameter int FRAME_W = FRAME_W_DEF
) (
  input  logic               lock_i,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output chk_res_t           res_o
);
  localparam int PAY_W = FRAME_W - 1;

  logic pay_par;
  assign pay_par       = ^frame_i[PAY_W-1:0];
  assign res_o.chk_en  = lock_i & frame_vld_i;
  assign res_o.par_err = pay_par ^ frame_i[PAY_W];
endmodule

// File: rtl/slpm_err_counter.sv
module slpm_err_counter
  import slpm_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  chk_res_t         res_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pass_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (!lock_i) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (res_i.chk_en) begin
      if (res_i.par_err) begin
        pass_q <= 1'b0;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else begin
        pass_q <= 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pass_o = pass_q;
endmodule

// File: rtl/slpm_reg_read.sv
module slpm_reg_read
  import slpm_pkg::*;
#(
  parameter int              CNT_W     = CNT_W_DEF,
  parameter int              ADDR_W    = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE_ADDR_DEF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [CNT_W-BYTE_W-1:0] shadow_o
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int SH_W   = CNT_W - BYTE_W;

  logic [NBYTES-1:0]             hit;
  logic [NBYTES-1:0][BYTE_W-1:0] byte_val;
  logic [SH_W-1:0]               shadow_q;
  logic [BYTE_W-1:0]             rd_mux;
  logic [BYTE_W-1:0]             rd_q;

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    localparam logic [ADDR_W-1:0] B_ADDR = ADDR_W'(BASE_ADDR + ADDR_W'(gb));
    assign hit[gb] = (rd_addr_i == B_ADDR);
    if (gb == 0) begin : g_live
      assign byte_val[gb] = cnt_i[BYTE_W-1:0];
    end else begin : g_shadow
      assign byte_val[gb] = shadow_q[(gb-1)*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (hit[b]) rd_mux = byte_val[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rd_q     <= '0;
    end else begin
      if (!lock_i) shadow_q <= '0;
      else if (rd_en_i && hit[0]) shadow_q <= cnt_i[CNT_W-1:BYTE_W];
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  assign rd_data_o = rd_q;
  assign shadow_o  = shadow_q;
endmodule

// File: rtl/slpm_parity_monitor.sv
module slpm_parity_monitor
  import slpm_pkg::*;
#(
  parameter int                FRAME_W   = FRAME_W_DEF,
  parameter int                CNT_W     = CNT_W_DEF,
  parameter int                ADDR_W    = ADDR_W_DEF,
  parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE_ADDR_DEF)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lock_i,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               pass_o,
  output logic [BYTE_W-1:0]  rd_data_o
);
  chk_res_t               chk_res;
  logic [CNT_W-1:0]        err_cnt;
  logic [CNT_W-BYTE_W-1:0] shadow;

  slpm_parity_chk #(.FRAME_W(FRAME_W)) u_chk (
    .lock_i      (lock_i),
    .frame_vld_i (frame_vld_i),
    .frame_i     (frame_i),
    .res_o       (chk_res)
  );

  slpm_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .lock_i (lock_i),
    .res_i  (chk_res),
    .cnt_o  (err_cnt),
    .pass_o (pass_o)
  );

  slpm_reg_read #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .lock_i    (lock_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (err_cnt),
    .rd_data_o (rd_data_o),
    .shadow_o  (shadow)
  );
endmodule

// File: rtl/slpm_parity_monitor_chk.sv
module slpm_parity_monitor_chk #(
  parameter int                FRAME_W   = 28,
  parameter int                CNT_W     = 16,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h1A
) (
  input logic               clk,
  input logic               rst,
  input logic               lock_i,
  input logic               frame_vld_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic               pass_o,
  input logic [7:0]         rd_data_o,
  input logic [CNT_W-1:0]   err_cnt,
  input logic [CNT_W-9:0]   shadow
);
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);
  localparam logic [CNT_W-1:0]  MAXV    = {CNT_W{1'b1}};

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + CNT_W'(1)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (lock_i && err_cnt == MAXV) |=> err_cnt == MAXV);

  p_unlock_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> (err_cnt == '0 && shadow == '0));

  p_pass_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (lock_i && frame_vld_i && (^frame_i)) |=> !pass_o);

  p_pass_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_i && frame_vld_i && !(^frame_i)) |=> pass_o);

  p_pass_unlock_r7: assert property (@(posedge clk) disable iff (rst)
    !lock_i |=> !pass_o);

  p_hi_shadow_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == HI_ADDR) |=> rd_data_o == $past(shadow[7:0]));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i != BASE_ADDR && rd_addr_i != HI_ADDR) |=> rd_data_o == 8'h00);
endmodule

bind slpm_parity_monitor slpm_parity_monitor_chk #(
  .FRAME_W(FRAME_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .lock_i(lock_i), .frame_vld_i(frame_vld_i),
  .frame_i(frame_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .pass_o(pass_o), .rd_data_o(rd_data_o), .err_cnt(err_cnt), .shadow(shadow)
);

// File: tb/slpm_parity_monitor_tb.sv
`timescale 1ns/1ps
module slpm_parity_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_i = 1'b0;
  logic        frame_vld_i = 1'b0;
  logic [27:0] frame_i = '0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  rd_addr_i = '0;
  logic        pass_o;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  int exp_cnt = 0;

  always #4 clk = ~clk;

  slpm_parity_monitor dut_i (
    .clk(clk), .rst(rst), .lock_i(lock_i), .frame_vld_i(frame_vld_i),
    .frame_i(frame_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .pass_o(pass_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [27:0] mk_frame(input logic [26:0] pay, input bit bad);
    return {(^pay) ^ bad, pay};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // inputs change on falling edges; outputs are sampled one falling edge later
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [26:0] pay, input bit bad, input bit vld);
    frame_i = mk_frame(pay, bad);
    frame_vld_i = vld;
    step();
    frame_vld_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en_i = 1'b1;
    rd_addr_i = a;
    step();
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(8'h1A, lo);
    rd(8'h1B, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset();
    int v;
    chk("R10 pass after reset", pass_o, 0);
    chk("R10 rd_data after reset", rd_data_o, 0);
    lock_i = 1'b1;
    step();
    rd16(v);
    chk("R10 count after reset", v, 0);
    chk("R6 pass low with no frames", pass_o, 0);
  endtask

  task automatic t_good();
    send(27'h5A5A5A5, 1'b0, 1'b1);
    chk("R6 pass rises on good frame", pass_o, 1);
    send(27'h0000000, 1'b0, 1'b1);
    send(27'h7FFFFFF, 1'b0, 1'b1);
    chk("R1 good frames keep pass", pass_o, 1);
  endtask

  task automatic t_bad();
    int v;
    send(27'h1234567, 1'b1, 1'b1); exp_cnt++;
    chk("R5 pass low after bad frame", pass_o, 0);
    send(27'h7FFFFFF, 1'b1, 1'b1); exp_cnt++;
    send(27'h0000001, 1'b1, 1'b1); exp_cnt++;
    chk("R5 pass stays low", pass_o, 0);
    send(27'h0ABCDEF, 1'b0, 1'b1);
    chk("R6 pass back high after good frame", pass_o, 1);
    rd16(v);
    chk("R2 count after three bad frames", v, exp_cnt);
  endtask

  task automatic t_vld_low();
    int v;
    send(27'h3333333, 1'b1, 1'b0);
    chk("R1 invalid bad frame keeps pass", pass_o, 1);
    rd16(v);
    chk("R1 invalid frame not counted", v, exp_cnt);
  endtask

  task automatic t_shadow();
    logic [7:0] lo, hi;
    int v;
    frame_i = mk_frame(27'h0000F0F, 1'b1);
    frame_vld_i = 1'b1;
    while (exp_cnt < 16'h01FF) begin step(); exp_cnt++; end
    frame_vld_i = 1'b0;
    rd(8'h1A, lo);
    chk("R8 low byte", lo, 8'hFF);
    send(27'h0000F0F, 1'b1, 1'b1); exp_cnt++;
    rd(8'h1B, hi);
    chk("R8 high byte from shadow", hi, 8'h01);
    rd16(v);
    chk("R8 fresh 16-bit read", v, 16'h0200);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(8'h1C, d); chk("R9 addr 0x1C", d, 0);
    rd(8'h19, d); chk("R9 addr 0x19", d, 0);
    rd(8'h00, d); chk("R9 addr 0x00", d, 0);
  endtask

  task automatic t_unlock();
    int v;
    send(27'h0000011, 1'b0, 1'b1);
    lock_i = 1'b0;
    step();
    chk("R6 pass low while unlocked", pass_o, 0);
    send(27'h1111111, 1'b1, 1'b1);
    send(27'h2222222, 1'b0, 1'b1);
    chk("R7 good frame ignored when unlocked", pass_o, 0);
    lock_i = 1'b1;
    exp_cnt = 0;
    rd16(v);
    chk("R4 count cleared by lock loss", v, 0);
    chk("R7 frames while unlocked not counted", v, 0);
    send(27'h2222222, 1'b0, 1'b1);
    chk("R6 pass rises after relock", pass_o, 1);
  endtask

  task automatic t_saturate();
    int v;
    frame_i = mk_frame(27'h0C0FFEE, 1'b1);
    frame_vld_i = 1'b1;
    for (int i = 0; i < 65540; i++) step();
    frame_vld_i = 1'b0;
    rd16(v);
    chk("R3 count saturates", v, 16'hFFFF);
    chk("R5 pass low after errors", pass_o, 0);
  endtask

  initial begin
    @(negedge clk);
    step();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good();
    t_bad();
    t_vld_low();
    t_shadow();
    t_unmapped();
    t_unlock();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule